// File: doc/BRIEF.md
# Interrupt Pin Function Mapper

This block routes a common set of four event conditions onto two interrupt output pins: data ready, activity, inactivity and awake. Each pin has an 8-bit map register. Its enable bits choose which events may assert the pin, and its polarity bit chooses whether an asserted pin drives high or low. A plain register write port loads the map registers, and a combinational read port returns their contents.

The block ORs the enabled conditions for each pin and applies that pin's polarity. It registers the result as the pin value. Alongside the pin value it gives an output-enable. The output-enable drops whenever the pin's map has no event selected, so the pad floats. Event detection, the serial host interface and any use of the pins as inputs are outside this block.

Top module: `irq_pin_mapper`

## Requirements
- R1: After a synchronous active-low reset, both map registers hold 0x00 and both pins show pin_out = 0 and pin_oe = 0.
- R2: The map register for pin 0 sits at address 0x3B and the one for pin 1 at 0x3C. A write to either address stores the data (reserved bits excepted), and it can be read back at the same address combinationally, in the same cycle the address is presented.
- R3: Bits 3:1 of each map register are reserved: they always read as 0, whatever was written.
- R4: A write to any address other than 0x3B and 0x3C leaves both map registers unchanged. A read from such an address returns 0x00.
- R5: Map bit 0 enables data ready, bit 4 inactivity, bit 6 awake and bit 5 activity. A pin is asserted exactly when at least one enabled event is high. Any combination of enables is allowed.
- R6: Map bit 7 sets polarity. With 0 the pin is active high (pin_out = asserted). With 1 it is active low (pin_out = not asserted). When not asserted, the pin rests at the level of bit 7.
- R7: pin_oe is 1 exactly when at least one of map bits 0, 4, 5, 6 is set. Otherwise the pin is left high-impedance.
- R8: pin_out and pin_oe are registered. They reflect the map and event values sampled at the previous rising clock edge, so there is one cycle of latency from an event change or a map write.
- R9: The two pins are independent. A write or setting for one pin never alters the other pin's map, level or enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the map registers |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| evt_data_rdy | input | 1 | Data ready event condition |
| evt_inact | input | 1 | Inactivity event condition |
| evt_act | input | 1 | Activity event condition |
| evt_awake | input | 1 | Awake event condition |
| pin_out | output | 2 | Registered pin level, bit k for pin k |
| pin_oe | output | 2 | Registered output-enable, bit k for pin k |

## Verification
The embedded assertions check on every cycle that the reserved bits stay zero and that writes land only at a pin's own address. They also check that foreign writes leave the maps stable, and that the enable, the idle level and the polarity-adjusted level follow, one cycle later, the map and events that were sampled. The bench's sweeps are needed to show the field positions and address assignments against values computed independently. Only the bench can show that all 256 written values read back with reserved bits cleared, and that every map value combined with every event pattern gives the right level on one pin while the other pin is left undisturbed. The reset state and the exact one-cycle latency are also shown by bench scenarios.

// File: rtl/irq_map_pkg.sv
// Package: irq_map_pkg
// Shared constants for the interrupt pin mapper: the map register layout,
// the event ordering used on internal vectors and the writable-bit mask.
// Assumes an 8-bit map register with fixed field positions.
package irq_map_pkg;

    localparam int MAP_W   = 8;
    localparam int EVT_NUM = 4;
    localparam int POL_BIT = 7;

    // Internal event order: 0 data ready, 1 inactivity, 2 activity, 3 awake
    localparam int EVT_DRDY  = 0;
    localparam int EVT_INACT = 1;
    localparam int EVT_ACT   = 2;
    localparam int EVT_AWAKE = 3;

    // Map bit that enables each internal event index
    function automatic int fn_bit(input int evt_idx);
        case (evt_idx)
            EVT_DRDY:  return 0;
            EVT_INACT: return 4;
            EVT_ACT:   return 5;
            default:   return 6;
        endcase
    endfunction

    // Bits of a map register that hold state; all others read as zero
    function automatic logic [MAP_W-1:0] writable_mask();
        logic [MAP_W-1:0] m;
        m = '0;
        m[POL_BIT] = 1'b1;
        for (int e = 0; e < EVT_NUM; e++) begin
            m[fn_bit(e)] = 1'b1;
        end
        return m;
    endfunction

    typedef logic [MAP_W-1:0]   map_word_t;
    typedef logic [EVT_NUM-1:0] evt_vec_t;

endpackage

// File: rtl/irq_map_regs.sv
// Module: irq_map_regs
// Holds one map register per pin at consecutive addresses starting at
// BASE_ADDR. Writes are masked so reserved bits stay zero; reads are a
// combinational lookup of the presented address (zero for foreign ones).
// Assumes a single-cycle write strobe with address and data valid with it.
module irq_map_regs
    import irq_map_pkg::*;
#(
    parameter int              NUM_PINS  = 2,
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h3B
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [MAP_W-1:0]      wdata,
    output logic [MAP_W-1:0]      rdata,
    output map_word_t             map_q [NUM_PINS]
);

    localparam map_word_t WR_MASK = writable_mask();

    logic [NUM_PINS-1:0] sel;
    logic                any_sel;
    logic                armed_q;

    // Marks that a reset edge has been seen, to gate history-based checks
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b1;
    end

    generate
        for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin_reg
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(BASE_ADDR) + k);

            // Address decode for this pin's register
            assign sel[k] = (addr == MY_ADDR);

            // Map register storage with reserved bits masked off
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    map_q[k] <= '0;
                end else if (wr_en && sel[k]) begin
                    map_q[k] <= wdata & WR_MASK;
                end
            end

            AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                armed_q |-> (map_q[k][3:1] == 3'b000)); // R3

            AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
                (armed_q && wr_en && addr == MY_ADDR) |=>
                    (map_q[k] == ($past(wdata) & WR_MASK))); // R2

            AST_FOREIGN_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (armed_q && wr_en && addr != MY_ADDR) |=> $stable(map_q[k])); // R4
        end
    endgenerate

    assign any_sel = |sel;

    // Combinational read mux over the pin registers
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_PINS; k++) begin
            if (sel[k]) rdata = rdata | map_q[k];
        end
    end

    AST_FOREIGN_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !any_sel) |-> (rdata == '0)); // R4

endmodule

// File: rtl/irq_pin_drive.sv
// Module: irq_pin_drive
// Produces one interrupt pin from its map word and the shared events:
// ORs the enabled events, applies polarity, and registers both the level
// and the output-enable. Assumes events are synchronous to clk.
module irq_pin_drive
    import irq_map_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  map_word_t  map_word,
    input  evt_vec_t   evt,
    output logic       pin_out,
    output logic       pin_oe
);

    evt_vec_t fn_en;
    logic     hit;
    logic     pol;
    logic     armed_q;

    // Marks that a reset edge has been seen, to gate history-based checks
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b1;
    end

    generate
        for (genvar e = 0; e < EVT_NUM; e++) begin : g_fn
            // Pick the enable bit of event e from its field position
            assign fn_en[e] = map_word[fn_bit(e)];
        end
    endgenerate

    assign hit = |(fn_en & evt);
    assign pol = map_word[POL_BIT];

    // Registered pin level and enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out <= 1'b0;
            pin_oe  <= 1'b0;
        end else begin
            pin_out <= hit ^ pol;
            pin_oe  <= |fn_en;
        end
    end

    AST_OE_FOLLOWS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |=> (pin_oe == ($past(map_word[0]) | $past(map_word[4]) |
                                $past(map_word[5]) | $past(map_word[6])))); // R7

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !hit) |=> (pin_out == $past(map_word[POL_BIT]))); // R6

    AST_ASSERTED_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && hit) |=> (pin_out == !$past(map_word[POL_BIT]))); // R5

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && fn_en == '0) |=> (!pin_oe && pin_out == $past(pol))); // R7

endmodule

// File: rtl/irq_pin_mapper.sv
// Module: irq_pin_mapper
// Top level of the interrupt pin mapper: map register file plus one
// pin driver per interrupt pin. Assumes a synchronous register port and
// event inputs synchronous to clk.
module irq_pin_mapper
    import irq_map_pkg::*;
#(
    parameter int                NUM_PINS  = 2,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h3B
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [MAP_W-1:0]    reg_wdata,
    output logic [MAP_W-1:0]    reg_rdata,
    input  logic                evt_data_rdy,
    input  logic                evt_inact,
    input  logic                evt_act,
    input  logic                evt_awake,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    map_word_t map_q [NUM_PINS];
    evt_vec_t  evt;

    // Gather event inputs into the internal order
    always_comb begin
        evt            = '0;
        evt[EVT_DRDY]  = evt_data_rdy;
        evt[EVT_INACT] = evt_inact;
        evt[EVT_ACT]   = evt_act;
        evt[EVT_AWAKE] = evt_awake;
    end

    irq_map_regs #(
        .NUM_PINS  (NUM_PINS),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .map_q (map_q)
    );

    generate
        for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
            irq_pin_drive drv_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .map_word (map_q[k]),
                .evt      (evt),
                .pin_out  (pin_out[k]),
                .pin_oe   (pin_oe[k])
            );
        end
    endgenerate

endmodule

// File: tb/irq_pin_mapper_tb.sv
// Bench: irq_pin_mapper_tb_top
// Sweeps map values, addresses and event patterns; expected values are
// computed from the requirement text, not from the design.
module irq_pin_mapper_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       evt_data_rdy = 1'b0;
    logic       evt_inact = 1'b0;
    logic       evt_act = 1'b0;
    logic       evt_awake = 1'b0;
    logic [1:0] pin_out;
    logic [1:0] pin_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    irq_pin_mapper dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_en    (reg_wr_en),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .evt_data_rdy (evt_data_rdy),
        .evt_inact    (evt_inact),
        .evt_act      (evt_act),
        .evt_awake    (evt_awake),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
        end
    endtask

    // Expected stored value per R2/R3: reserved bits 3:1 cleared
    function automatic logic [7:0] stored(input logic [7:0] v);
        return v & 8'hF1;
    endfunction

    // Expected level per R5/R6 (bits 0,4,5,6 enable; bit 7 polarity)
    function automatic logic exp_level(input logic [7:0] m, input logic [3:0] ev);
        logic h;
        h = (m[0] & ev[0]) | (m[4] & ev[1]) | (m[5] & ev[2]) | (m[6] & ev[3]);
        return h ^ m[7];
    endfunction

    function automatic logic exp_oe(input logic [7:0] m);
        return m[0] | m[4] | m[5] | m[6];
    endfunction

    // ev: 0 data ready, 1 inactivity, 2 activity, 3 awake
    task automatic set_evt(input logic [3:0] ev);
        evt_data_rdy = ev[0];
        evt_inact    = ev[1];
        evt_act      = ev[2];
        evt_awake    = ev[3];
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] m0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pin_oe", pin_oe, 0);
        check("R1 pin_out", pin_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_check("R1 map0", 8'h3B, 8'h00);
        rd_check("R1 map1", 8'h3C, 8'h00);

        // R2/R3: every value written to both registers reads back masked
        for (int v = 0; v < 256; v++) begin
            wr(8'h3B, 8'(v));
            rd_check("R2 R3 map0 readback", 8'h3B, stored(8'(v)));
            wr(8'h3C, 8'(255 - v));
            rd_check("R2 R3 map1 readback", 8'h3C, stored(8'(255 - v)));
            rd_check("R9 map0 kept", 8'h3B, stored(8'(v)));
        end

        // R4: foreign addresses neither write nor read
        wr(8'h3B, 8'hA1);
        wr(8'h3C, 8'h50);
        for (int a = 0; a < 256; a++) begin
            if (a != 8'h3B && a != 8'h3C) begin
                wr(8'(a), 8'hFF);
                rd_check("R4 foreign read", 8'(a), 8'h00);
            end
        end
        rd_check("R4 map0 unchanged", 8'h3B, 8'hA1);
        rd_check("R4 map1 unchanged", 8'h3C, 8'h50);
        @(negedge clk);
        check("R4 pins unchanged oe", pin_oe, 2'b11);

        // R5/R6/R7/R9: every map value on pin 0 against every event pattern,
        // pin 1 mapped to activity only, active high
        wr(8'h3C, 8'h20);
        for (int v = 0; v < 256; v++) begin
            m0 = stored(8'(v));
            wr(8'h3B, 8'(v));
            for (int ev = 0; ev < 16; ev++) begin
                set_evt(4'(ev));
                @(negedge clk);
                check("R5 R6 pin0 level", pin_out[0], exp_level(m0, 4'(ev)));
                check("R7 pin0 oe", pin_oe[0], exp_oe(m0));
                check("R9 pin1 level", pin_out[1], exp_level(8'h20, 4'(ev)));
                check("R9 pin1 oe", pin_oe[1], 1);
            end
        end

        // R8: one cycle latency on event change (active low, awake only)
        wr(8'h3B, 8'hC0);
        set_evt(4'b0000);
        @(negedge clk);
        check("R8 idle high", pin_out[0], 1);
        set_evt(4'b1000);
        @(posedge clk);
        #1;
        check("R8 level after edge", pin_out[0], 0);
        set_evt(4'b0000);
        @(negedge clk);
        check("R8 held before edge", pin_out[0], 0);
        @(posedge clk);
        #1;
        check("R8 released after edge", pin_out[0], 1);

        // R8: map write takes effect one edge after it lands
        set_evt(4'b0001);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = 8'h3B;
        reg_wdata = 8'h01;
        @(posedge clk);
        #1;
        reg_wr_en = 1'b0;
        check("R8 old map still shown", pin_oe[0], 1);
        check("R8 old level", pin_out[0], 1);
        @(posedge clk);
        #1;
        check("R8 new map level", pin_out[0], 1);
        wr(8'h3B, 8'h00);
        @(negedge clk);
        check("R7 unmapped oe low", pin_oe[0], 0);

        // R1: reset mid-run returns to reset state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset oe", pin_oe, 0);
        check("R1 reset out", pin_out, 0);
        rd_check("R1 reset map1", 8'h3C, 8'h00);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule